// File: doc/BRIEF.md
# APB USB Endpoint FIFO Bridge

This block connects a 32-bit APB slave port to the receive and transmit FIFOs of a USB device endpoint. A CPU or DMA engine reaches both FIFOs through one data-port address. The bridge turns each APB access into a single-cycle FIFO read or write strobe. It never strobes a FIFO that cannot take the access, so a bus transfer cannot by itself cause a FIFO error.

The bridge asks for receive DMA service as soon as the receive FIFO reports full. It asks for transmit DMA service only after software has set a transmit-enable bit. When the USB protocol engine reports an OUT token, the bridge latches a pending flag and can raise a level interrupt to the CPU. An overrun or underrun reported by a FIFO is held in a sticky error flag. While either error flag is set, every FIFO strobe and every DMA request is held off, until software clears the flag.

The same APB port gives read-only access to a small descriptor ROM, whose contents are computed from a formula. The asynchronous active-low reset is released to the logic through a two-stage synchronizer.

Top module: `apb_usb_fifo_bridge`

## Requirements
- R1: A read of the data port (offset 0x08) in the APB access phase (psel and penable high) pulses `rx_rd` for exactly that cycle and returns `rx_data` in `prdata[7:0]`, with zeros above. `pready` is always 1.
- R2: No FIFO strobe is issued toward a FIFO that cannot accept it: `rx_rd` stays low while `rx_empty` is 1, and `tx_wr` stays low while `tx_full` is 1.
- R3: A write of the data port in the access phase pulses `tx_wr` for that cycle, with `tx_wdata` equal to `pwdata[7:0]`.
- R4: `dma_rx_req` is high exactly when `rx_full` is 1, no error flag is set and `rx_rd` is low, so it drops in the same cycle as the read strobe.
- R5: `dma_tx_req` is high only while the transmit-enable bit (control bit 0, offset 0x00) is set, `tx_full` is 0, no error flag is set and `tx_wr` is low.
- R6: A one-cycle pulse on `out_token` sets the OUT-pending flag (status bit 6). `irq` equals that flag ANDed with the interrupt-enable bit (control bit 1). Writing 1 to status bit 6 clears the flag. A new token in the same cycle as the clear wins.
- R7: A pulse on `rx_overrun` sets the sticky RX error flag (status bit 4). While it is set, `rx_rd`, `tx_wr`, `dma_rx_req` and `dma_tx_req` all stay low. Writing 1 to status bit 4 clears it and releases the gating.
- R8: A pulse on `tx_underrun` sets the sticky TX error flag (status bit 5), with the same gating as R7. Writing 1 to status bit 5 clears it.
- R9: A read of the status register (offset 0x04) returns, from bit 0 up: `rx_full`, `rx_empty`, `tx_full`, `tx_empty`, the RX error flag, the TX error flag and the OUT-pending flag, with zeros above. A read of the control register returns transmit-enable in bit 0 and interrupt-enable in bit 1.
- R10: A read in the range 0x100 to 0x100+ROM_BYTES-1 returns a 32-bit word of four ROM bytes, little-endian. ROM byte i is ((i*29) mod 256) XOR 0xA5. Writes to the ROM have no effect.
- R11: A read of any other address, including the first address past the ROM, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| rx_full | input | 1 | Receive FIFO full |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_overrun | input | 1 | Receive FIFO overrun pulse |
| rx_rd | output | 1 | Receive FIFO read strobe |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_underrun | input | 1 | Transmit FIFO underrun pulse |
| tx_wr | output | 1 | Transmit FIFO write strobe |
| tx_wdata | output | 8 | Transmit FIFO write byte |
| out_token | input | 1 | OUT token seen, one-cycle pulse |
| dma_rx_req | output | 1 | Receive DMA service request |
| dma_tx_req | output | 1 | Transmit DMA service request |
| irq | output | 1 | CPU interrupt, level |

## Verification
The bench builds the bridge with ADDR_W of 12 and ROM_BYTES reduced to 16. With that ROM size, a few reads cover every ROM word and also reach the first address past the ROM, where reads must return zero. The default 64-byte ROM keeps that boundary further away. The bench also covers the same-cycle drop of each DMA request against its strobe, and the release of strobe and DMA gating after each sticky error is cleared.

// File: rtl/usbbr_pkg.sv
package usbbr_pkg;
  localparam int DW = 32;

  localparam int OFS_CTRL = 'h000;
  localparam int OFS_STAT = 'h004;
  localparam int OFS_DATA = 'h008;
  localparam int ROM_BASE = 'h100;

  // status bit positions
  localparam int ST_RXFULL  = 0;
  localparam int ST_RXEMPTY = 1;
  localparam int ST_TXFULL  = 2;
  localparam int ST_TXEMPTY = 3;
  localparam int ST_RXERR   = 4;
  localparam int ST_TXERR   = 5;
  localparam int ST_OUTPEND = 6;

  typedef struct packed {
    logic irq_en;
    logic tx_en;
  } ctrl_t;

  function automatic logic [7:0] rom_byte(int unsigned i);
    return 8'(((i * 29) & 255) ^ 165);
  endfunction
endpackage

// File: rtl/usbbr_regs.sv
module usbbr_regs
  import usbbr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_stat,
  input  logic [DW-1:0] wdata,
  input  logic          ovr_in,
  input  logic          udr_in,
  input  logic          tok_in,
  output ctrl_t         ctrl,
  output logic          rx_err,
  output logic          tx_err,
  output logic          out_pend,
  output logic          irq
);
  ctrl_t ctrl_d;
  logic  rx_err_d, tx_err_d, pend_d;

  always_comb begin
    ctrl_d   = ctrl;
    rx_err_d = rx_err;
    tx_err_d = tx_err;
    pend_d   = out_pend;
    if (wr_ctrl) begin
      ctrl_d.tx_en  = wdata[0];
      ctrl_d.irq_en = wdata[1];
    end
    if (wr_stat && wdata[ST_RXERR])   rx_err_d = 1'b0;
    if (wr_stat && wdata[ST_TXERR])   tx_err_d = 1'b0;
    if (wr_stat && wdata[ST_OUTPEND]) pend_d   = 1'b0;
    if (ovr_in) rx_err_d = 1'b1;
    if (udr_in) tx_err_d = 1'b1;
    if (tok_in) pend_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      rx_err   <= 1'b0;
      tx_err   <= 1'b0;
      out_pend <= 1'b0;
    end else begin
      ctrl     <= ctrl_d;
      rx_err   <= rx_err_d;
      tx_err   <= tx_err_d;
      out_pend <= pend_d;
    end
  end

  assign irq = out_pend & ctrl.irq_en;

  // R6
  tok_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tok_in |=> out_pend);
  // R6
  pend_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[ST_OUTPEND] && !tok_in) |=> !out_pend);
  // R7
  rx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_err && !(wr_stat && wdata[ST_RXERR])) |=> rx_err);
  // R8
  tx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_err && !(wr_stat && wdata[ST_TXERR])) |=> tx_err);
endmodule

// File: rtl/usbbr_rom.sv
module usbbr_rom
  import usbbr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int ROM_BYTES = 64
) (
  input  logic [ADDR_W-1:0] offset,
  output logic [DW-1:0]     word
);
  localparam int IDX_W = (ROM_BYTES > 1) ? $clog2(ROM_BYTES) : 1;

  logic [7:0] bytes [ROM_BYTES];

  for (genvar g = 0; g < ROM_BYTES; g++) begin : g_byte
    assign bytes[g] = rom_byte(g);
  end

  always_comb begin
    word = '0;
    for (int k = 0; k < 4; k++) begin
      logic [ADDR_W-1:0] ba;
      ba = {offset[ADDR_W-1:2], 2'b00} + ADDR_W'(k);
      if (ba < ADDR_W'(ROM_BYTES)) word[8*k +: 8] = bytes[ba[IDX_W-1:0]];
    end
  end
endmodule

// File: rtl/apb_usb_fifo_bridge.sv
module apb_usb_fifo_bridge
  import usbbr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int ROM_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  output logic              pready,
  input  logic              rx_full,
  input  logic              rx_empty,
  input  logic [7:0]        rx_data,
  input  logic              rx_overrun,
  output logic              rx_rd,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic              tx_underrun,
  output logic              tx_wr,
  output logic [7:0]        tx_wdata,
  input  logic              out_token,
  output logic              dma_rx_req,
  output logic              dma_tx_req,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(OFS_DATA);
  localparam logic [ADDR_W-1:0] A_ROM   = ADDR_W'(ROM_BASE);
  localparam logic [ADDR_W-1:0] A_ROMND = ADDR_W'(ROM_BASE + ROM_BYTES);

  // reset: asserted asynchronously, released through two flops
  logic rst_q1, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_s  <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_s  <= rst_q1;
    end
  end

  logic access, rd_acc, wr_acc;
  logic sel_ctrl, sel_stat, sel_data, sel_rom;
  logic err_any, rx_err, tx_err, out_pend;
  ctrl_t ctrl;
  logic [DW-1:0] rom_word;

  assign pready   = 1'b1;
  assign access   = psel & penable;
  assign rd_acc   = access & ~pwrite;
  assign wr_acc   = access & pwrite;
  assign sel_ctrl = (paddr == A_CTRL);
  assign sel_stat = (paddr == A_STAT);
  assign sel_data = (paddr == A_DATA);
  assign sel_rom  = (paddr >= A_ROM) && (paddr < A_ROMND);
  assign err_any  = rx_err | tx_err;

  usbbr_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_s),
    .wr_ctrl  (wr_acc & sel_ctrl),
    .wr_stat  (wr_acc & sel_stat),
    .wdata    (pwdata),
    .ovr_in   (rx_overrun),
    .udr_in   (tx_underrun),
    .tok_in   (out_token),
    .ctrl     (ctrl),
    .rx_err   (rx_err),
    .tx_err   (tx_err),
    .out_pend (out_pend),
    .irq      (irq)
  );

  usbbr_rom #(.ADDR_W(ADDR_W), .ROM_BYTES(ROM_BYTES)) u_rom (
    .offset (paddr - A_ROM),
    .word   (rom_word)
  );

  // strobes and requests
  assign rx_rd      = rd_acc & sel_data & ~rx_empty & ~err_any;
  assign tx_wr      = wr_acc & sel_data & ~tx_full & ~err_any;
  assign tx_wdata   = pwdata[7:0];
  assign dma_rx_req = rx_full & ~err_any & ~rx_rd;
  assign dma_tx_req = ctrl.tx_en & ~tx_full & ~err_any & ~tx_wr;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (sel_ctrl) prdata[1:0] = {ctrl.irq_en, ctrl.tx_en};
      else if (sel_stat) begin
        prdata[ST_RXFULL]  = rx_full;
        prdata[ST_RXEMPTY] = rx_empty;
        prdata[ST_TXFULL]  = tx_full;
        prdata[ST_TXEMPTY] = tx_empty;
        prdata[ST_RXERR]   = rx_err;
        prdata[ST_TXERR]   = tx_err;
        prdata[ST_OUTPEND] = out_pend;
      end
      else if (sel_data) prdata[7:0] = rx_data;
      else if (sel_rom)  prdata = rom_word;
    end
  end

  // R2
  rx_rd_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_s)
    rx_rd |-> !rx_empty);
  // R2
  tx_wr_notfull_chk: assert property (@(posedge clk) disable iff (!rst_s)
    tx_wr |-> !tx_full);
  // R1
  rd_strobe_access_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rx_rd || tx_wr) |-> (psel && penable));
  // R4
  rx_req_full_chk: assert property (@(posedge clk) disable iff (!rst_s)
    dma_rx_req |-> (rx_full && !rx_rd));
  // R5
  tx_req_enable_chk: assert property (@(posedge clk) disable iff (!rst_s)
    dma_tx_req |-> (ctrl.tx_en && !tx_wr));
  // R7
  err_gates_all_chk: assert property (@(posedge clk) disable iff (!rst_s)
    err_any |-> !(rx_rd || tx_wr || dma_rx_req || dma_tx_req));
endmodule

// File: tb/tb_apb_usb_fifo_bridge.sv
module tb_apb_usb_fifo_bridge;
  localparam int ADDR_W = 12;
  localparam int ROMB   = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic psel, penable, pwrite;
  logic [ADDR_W-1:0] paddr;
  logic [31:0] pwdata, prdata;
  logic pready;
  logic rx_full, rx_empty, rx_overrun, rx_rd;
  logic [7:0] rx_data, tx_wdata;
  logic tx_full, tx_empty, tx_underrun, tx_wr;
  logic out_token, dma_rx_req, dma_tx_req, irq;

  always #2.5 clk = ~clk;

  apb_usb_fifo_bridge #(.ADDR_W(ADDR_W), .ROM_BYTES(ROMB)) dut (.*);

  int n_chk = 0, n_fail = 0;
  int cnt_rd = 0, cnt_wr = 0;
  logic [7:0] exp_wdata = 8'h00;
  logic [31:0] exp_q [$];
  string tag_q [$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares read data and strobe side effects at the falling edge
  always @(negedge clk) begin
    if (rst_n && psel && penable && !pwrite && exp_q.size() > 0)
      check(tag_q.pop_front(), prdata, exp_q.pop_front());
    if (rx_rd) begin
      cnt_rd++;
      check("R4 req drops with rd", {31'b0, dma_rx_req}, 32'd0);
    end
    if (tx_wr) begin
      cnt_wr++;
      check("R3 wdata", {24'b0, tx_wdata}, {24'b0, exp_wdata});
      check("R5 req drops with wr", {31'b0, dma_tx_req}, 32'd0);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic apb(logic wr, logic [ADDR_W-1:0] a, logic [31:0] d);
    cyc();
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    cyc();
    penable = 1'b1;
    cyc();
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  // driver: pushes the expected read value to the scoreboard
  task automatic apb_read(logic [ADDR_W-1:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    apb(1'b0, a, 32'h0);
  endtask

  task automatic pulse(ref logic s);
    cyc(); s = 1'b1; cyc(); s = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  function automatic logic [7:0] rb(int i);
    return (i < ROMB) ? 8'(((i * 29) & 255) ^ 165) : 8'h00;
  endfunction

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r0, w0;
    rst_n = 1'b0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    rx_full = 0; rx_empty = 1; rx_data = 8'h00; rx_overrun = 0;
    tx_full = 0; tx_empty = 1; tx_underrun = 0; out_token = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    settle();
    check("R1 pready", {31'b0, pready}, 32'd1);
    check("R4 reset rx req", {31'b0, dma_rx_req}, 32'd0);
    check("R5 reset tx req", {31'b0, dma_tx_req}, 32'd0);
    check("R6 reset irq", {31'b0, irq}, 32'd0);
    apb_read(12'h000, 32'h0, "R9 ctrl reset");
    apb_read(12'h004, 32'h0A, "R9 status reset");

    // R1 receive read
    rx_empty = 0; rx_data = 8'h5C;
    r0 = cnt_rd;
    apb_read(12'h008, 32'h5C, "R1 data read");
    settle();
    check("R1 one rd pulse", cnt_rd - r0, 1);

    // R2 blocked strobes
    rx_empty = 1; r0 = cnt_rd;
    apb_read(12'h008, 32'h5C, "R1 data value while empty");
    settle();
    check("R2 no rd when empty", cnt_rd - r0, 0);
    tx_full = 1; w0 = cnt_wr;
    apb(1'b1, 12'h008, 32'h11);
    settle();
    check("R2 no wr when full", cnt_wr - w0, 0);
    tx_full = 0;

    // R3 transmit write
    exp_wdata = 8'hE7; w0 = cnt_wr;
    apb(1'b1, 12'h008, 32'hABCD12E7);
    settle();
    check("R3 one wr pulse", cnt_wr - w0, 1);

    // R4 receive DMA
    rx_full = 1; rx_empty = 0; rx_data = 8'h33;
    settle();
    check("R4 rx req on full", {31'b0, dma_rx_req}, 32'd1);
    apb_read(12'h008, 32'h33, "R1 read while full");
    rx_full = 0;
    settle();
    check("R4 rx req off", {31'b0, dma_rx_req}, 32'd0);
    rx_empty = 1;

    // R5 transmit DMA
    settle();
    check("R5 no tx req w/o enable", {31'b0, dma_tx_req}, 32'd0);
    apb(1'b1, 12'h000, 32'h1);
    settle();
    check("R5 tx req enabled", {31'b0, dma_tx_req}, 32'd1);
    apb_read(12'h000, 32'h1, "R9 ctrl readback");
    tx_full = 1;
    settle();
    check("R5 tx req off when full", {31'b0, dma_tx_req}, 32'd0);
    tx_full = 0;
    exp_wdata = 8'h9A;
    apb(1'b1, 12'h008, 32'h9A);

    // R6 OUT token interrupt
    apb(1'b1, 12'h000, 32'h3);
    pulse(out_token);
    settle();
    check("R6 irq set", {31'b0, irq}, 32'd1);
    apb_read(12'h004, 32'h4A, "R6 R9 status pend");
    apb(1'b1, 12'h004, 32'h40);
    settle();
    check("R6 irq cleared", {31'b0, irq}, 32'd0);
    apb(1'b1, 12'h000, 32'h1);
    pulse(out_token);
    settle();
    check("R6 irq masked", {31'b0, irq}, 32'd0);
    apb_read(12'h004, 32'h4A, "R6 pend while masked");
    apb(1'b1, 12'h004, 32'h40);
    apb_read(12'h004, 32'h0A, "R6 pend cleared");

    // R7 overrun gating
    rx_full = 1; rx_empty = 0;
    pulse(rx_overrun);
    settle();
    check("R7 rx req gated", {31'b0, dma_rx_req}, 32'd0);
    check("R7 tx req gated", {31'b0, dma_tx_req}, 32'd0);
    apb_read(12'h004, 32'h19, "R7 status err");
    r0 = cnt_rd; w0 = cnt_wr;
    apb_read(12'h008, 32'h33, "R7 data value");
    apb(1'b1, 12'h008, 32'h55);
    settle();
    check("R7 no rd", cnt_rd - r0, 0);
    check("R7 no wr", cnt_wr - w0, 0);
    apb(1'b1, 12'h004, 32'h10);
    settle();
    check("R7 rx req released", {31'b0, dma_rx_req}, 32'd1);
    rx_full = 0; rx_empty = 1;

    // R8 underrun gating
    pulse(tx_underrun);
    settle();
    check("R8 tx req gated", {31'b0, dma_tx_req}, 32'd0);
    apb_read(12'h004, 32'h2A, "R8 status err");
    w0 = cnt_wr;
    apb(1'b1, 12'h008, 32'h66);
    settle();
    check("R8 no wr", cnt_wr - w0, 0);
    apb(1'b1, 12'h004, 32'h20);
    settle();
    check("R8 tx req released", {31'b0, dma_tx_req}, 32'd1);

    // R10 ROM words, R11 unmapped
    apb(1'b1, 12'h100, 32'hFFFFFFFF);
    for (int w = 0; w < ROMB / 4; w++)
      apb_read(12'h100 + 12'(4 * w),
               {rb(4*w+3), rb(4*w+2), rb(4*w+1), rb(4*w)}, "R10 rom word");
    apb_read(12'h100 + 12'(ROMB), 32'h0, "R11 past rom");
    apb_read(12'h00C, 32'h0, "R11 unmapped");

    cyc(3);
    check("scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule